// File: doc/BRIEF.md
# Prioritized Interrupt Controller Core

This core collects up to eight interrupt request lines from peripherals, resolves which pending request deserves the CPU, and raises a single interrupt output. Each line is captured into a request register, either on a rising edge or by following the line's level. A per-line mask keeps chosen lines out of the decision. A request reaches the CPU only when it outranks every line already in service, which gives fully nested handling.

The CPU answers with two acknowledge pulses. The first pulse moves the winning line from the request register into the in-service register. The second pulse returns an 8-bit vector: the upper five bits of a programmed base, followed by the 3-bit line number. If no line wins at the first pulse, the vector carries line number 7 and nothing enters service. The in-service bit is cleared either by an end-of-interrupt command or automatically at the second pulse. When rotation is enabled, the line just cleared from service drops to the lowest priority.

Configuration is a small register-write port with four addresses: mode, mask, base vector and command. A select input chooses whether the read port shows the request register or the in-service register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, int_o is 0, vec_valid_o is 0, and both the request and in-service readbacks are 0. The priority order starts with line 0 highest and line 7 lowest.
- R2: In edge mode (mode bit 0 = 0), a request bit is set by a 0-to-1 change on its line and stays set after the line returns low.
- R3: In level mode (mode bit 0 = 1), each request bit follows its line's level one cycle later.
- R4: Mask bit i at address 1 (1 = blocked) stops line i from raising int_o and from entering service. Its request bit is still captured.
- R5: The lowest-priority line L defines the order L+1, L+2, …, L (modulo 8). While no acknowledge is pending, int_o is 1 exactly when the highest-ranked unmasked pending request ranks strictly above the highest-ranked in-service line, or when nothing is in service.
- R6: On the first inta_i pulse, the winning line's in-service bit is set and its request bit is cleared. On the second pulse, vec_valid_o is 1 for the following cycle, with vec_o = {base[7:3], line}, where base is written at address 2.
- R7: If no line wins at the first pulse, the second pulse returns vec_o = {base[7:3], 3'b111} and no in-service bit changes.
- R8: A write to address 3 with data bit 0 = 1 (end of interrupt) clears only the highest-ranked in-service bit.
- R9: With mode bit 1 = 1 (automatic end of interrupt), the serviced line's in-service bit is cleared at the second pulse without a command.
- R10: With mode bit 2 = 1 (rotation), the line whose in-service bit is cleared, by command or automatically, becomes the lowest-priority line.
- R11: rd_data_o shows the request register when rd_sel_i = 0 and the in-service register when rd_sel_i = 1, in the same cycle.
- R12: int_o stays 0 from the first acknowledge pulse until the second pulse has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Peripheral request lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | 0 mode, 1 mask, 2 base vector, 3 command |
| cfg_wdata_i | input | 8 | Configuration write data |
| inta_i | input | 1 | Acknowledge pulse, one cycle per pulse |
| rd_sel_i | input | 1 | Readback select: 0 request, 1 in-service |
| rd_data_o | output | 8 | Selected register contents |
| int_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector returned after the second acknowledge pulse |
| vec_valid_o | output | 1 | vec_o is valid this cycle |

## Verification
Directed sequences test the resolver with specific patterns. A lower-ranked line arrives while a higher one is in service, which shows that nesting blocks the lower line. A higher-ranked line arrives in the same situation, which shows that strict ranking lets it through. A masked-only request separates the mask from the spurious-vector path. Two simultaneous requests after a rotation show whether the order wraps from the last serviced line. Random sparse request bursts then run against a bench reference model under randomly chosen edge/level, automatic/command end-of-interrupt and rotation settings. Randomly placed acknowledge pulses and commands in this phase expose mismatches in ordering between the end-of-interrupt command and the acknowledge sequence.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef enum logic {ST_IDLE, ST_ACK2} ack_st_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_BASE = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  localparam int MODE_LEVEL = 0;
  localparam int MODE_AEOI  = 1;
  localparam int MODE_ROT   = 2;
  localparam int MODE_W     = 3;
endpackage

// File: rtl/irc_req_latch.sv
module irc_req_latch #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               level_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [N_LINES-1:0] irr_o
);
  logic [N_LINES-1:0] prev_q, irr_d;

  always_comb begin
    irr_d = level_i ? irq_i : (irr_o | (irq_i & ~prev_q));
    if (clr_i) irr_d[clr_idx_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_o  <= '0;
    end else begin
      prev_q <= irq_i;
      irr_o  <= irr_d;
    end
  end
endmodule

// File: rtl/irc_prio_pick.sv
module irc_prio_pick #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [IDX_W-1:0]   low_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [IDX_W-1:0]   rank_o
);
  logic [IDX_W-1:0]   start;
  logic [N_LINES-1:0] rot;

  // rotate so the line after low_i sits at bit 0
  assign start = IDX_W'(low_i + 1'b1);
  assign rot   = (vec_i >> start) | (vec_i << (N_LINES - int'(start)));

  always_comb begin
    rank_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (rot[i]) rank_o = IDX_W'(i);
    end
  end

  assign valid_o = |rot;
  assign idx_o   = IDX_W'(rank_o + start);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irc_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [DATA_W-1:0]  cfg_wdata_i,
  input  logic               inta_i,
  input  logic               rd_sel_i,
  output logic [N_LINES-1:0] rd_data_o,
  output logic               int_o,
  output logic [DATA_W-1:0]  vec_o,
  output logic               vec_valid_o
);
  localparam int IDX_W  = $clog2(N_LINES);
  localparam int BASE_W = DATA_W - IDX_W;

  ack_st_e            st_q;
  logic [MODE_W-1:0]  mode_q;
  logic [N_LINES-1:0] mask_q, isr_q, isr_d, irr_q;
  logic [BASE_W-1:0]  base_q;
  logic [IDX_W-1:0]   low_q, low_d, fz_q;
  logic               spur_q;

  logic               level_q, aeoi_q, rot_q;
  logic               rq_valid, is_valid, win, ack1, ack2, eoi_cmd;
  logic [IDX_W-1:0]   rq_idx, rq_rank, is_idx, is_rank;

  assign level_q = mode_q[MODE_LEVEL];
  assign aeoi_q  = mode_q[MODE_AEOI];
  assign rot_q   = mode_q[MODE_ROT];

  irc_req_latch #(.N_LINES(N_LINES)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .level_i   (level_q),
    .clr_i     (ack1 && win),
    .clr_idx_i (rq_idx),
    .irr_o     (irr_q)
  );

  irc_prio_pick #(.N_LINES(N_LINES)) u_pick_req (
    .vec_i   (irr_q & ~mask_q),
    .low_i   (low_q),
    .valid_o (rq_valid),
    .idx_o   (rq_idx),
    .rank_o  (rq_rank)
  );

  irc_prio_pick #(.N_LINES(N_LINES)) u_pick_isr (
    .vec_i   (isr_q),
    .low_i   (low_q),
    .valid_o (is_valid),
    .idx_o   (is_idx),
    .rank_o  (is_rank)
  );

  // nested: only strictly higher rank than anything in service
  assign win     = rq_valid && (!is_valid || (rq_rank < is_rank));
  assign int_o   = (st_q == ST_IDLE) && win;
  assign ack1    = inta_i && (st_q == ST_IDLE);
  assign ack2    = inta_i && (st_q == ST_ACK2);
  assign eoi_cmd = cfg_we_i && (cfg_addr_i == ADDR_CMD) && cfg_wdata_i[0];

  assign rd_data_o = rd_sel_i ? isr_q : irr_q;

  // command clear is applied after the auto clear, so its rotation wins
  always_comb begin
    isr_d = isr_q;
    low_d = low_q;
    if (ack1 && win) isr_d[rq_idx] = 1'b1;
    if (ack2 && aeoi_q && !spur_q) begin
      isr_d[fz_q] = 1'b0;
      if (rot_q) low_d = fz_q;
    end
    if (eoi_cmd && is_valid) begin
      isr_d[is_idx] = 1'b0;
      if (rot_q) low_d = is_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      mode_q      <= '0;
      mask_q      <= '0;
      base_q      <= '0;
      isr_q       <= '0;
      low_q       <= '1;
      fz_q        <= '0;
      spur_q      <= 1'b0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      isr_q       <= isr_d;
      low_q       <= low_d;
      vec_valid_o <= 1'b0;
      if (cfg_we_i) begin
        unique case (cfg_addr_i)
          ADDR_MODE: mode_q <= cfg_wdata_i[MODE_W-1:0];
          ADDR_MASK: mask_q <= cfg_wdata_i[N_LINES-1:0];
          ADDR_BASE: base_q <= cfg_wdata_i[DATA_W-1:IDX_W];
          default: ;
        endcase
      end
      if (ack1) begin
        st_q   <= ST_ACK2;
        spur_q <= !win;
        fz_q   <= rq_idx;
      end
      if (ack2) begin
        st_q        <= ST_IDLE;
        vec_o       <= {base_q, spur_q ? {IDX_W{1'b1}} : fz_q};
        vec_valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irc_chk.sv
module irc_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               int_o,
  input logic               inta_i,
  input logic               vec_valid_o,
  input logic               ack_pend,
  input logic               level_q,
  input logic [N_LINES-1:0] isr_q,
  input logic [N_LINES-1:0] irr_q,
  input logic [N_LINES-1:0] mask_q
);
  // R4
  masked_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_q & ~$past(isr_q) & $past(mask_q)) == '0);

  // R12
  int_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pend |-> !int_o);

  // R6
  vec_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ($past(inta_i) && $past(ack_pend)));

  // R6
  one_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_q & ~$past(isr_q)) <= 1);

  // R6
  edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(level_q) |-> ((isr_q & ~$past(isr_q) & irr_q) == '0));
endmodule

bind irq_prio_ctrl irc_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .int_o       (int_o),
  .inta_i      (inta_i),
  .vec_valid_o (vec_valid_o),
  .ack_pend    (st_q == irc_pkg::ST_ACK2),
  .level_q     (level_q),
  .isr_q       (isr_q),
  .irr_q       (irr_q),
  .mask_q      (mask_q)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam realtime TCK = 8ns;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq = '0, wdata = '0;
  logic       we = 1'b0, inta = 1'b0, rsel = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] rd_data, vec;
  logic       int_w, vv;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  logic [7:0] m_irr, m_isr, m_mask, m_prev, m_base, m_vec;
  logic [2:0] m_mode;
  int         m_low, m_fz;
  bit         m_st, m_spur, m_vv;

  always #(TCK/2) clk = ~clk;

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .inta_i(inta), .rd_sel_i(rsel), .rd_data_o(rd_data),
    .int_o(int_w), .vec_o(vec), .vec_valid_o(vv)
  );

  function automatic int rank_of(int ln, int low);
    return (ln + 7 - low) % 8;
  endfunction

  function automatic int best(logic [7:0] v, int low);
    int b = -1;
    for (int r = 7; r >= 0; r--) begin
      int ln = (low + 1 + r) % 8;
      if (v[ln]) b = ln;
    end
    return b;
  endfunction

  function automatic bit m_win();
    int rq = best(m_irr & ~m_mask, m_low);
    int is = best(m_isr, m_low);
    return (rq >= 0) && (is < 0 || rank_of(rq, m_low) < rank_of(is, m_low));
  endfunction

  function automatic bit m_int();
    return !m_st && m_win();
  endfunction

  task automatic expect_v(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic model_reset();
    m_irr = 0; m_isr = 0; m_mask = 0; m_prev = 0; m_base = 0; m_vec = 0;
    m_mode = 0; m_low = 7; m_fz = 0; m_st = 0; m_spur = 0; m_vv = 0;
  endtask

  task automatic model_step(logic [7:0] i, bit w, logic [1:0] a, logic [7:0] d, bit ak);
    bit win = m_win();
    int rq = best(m_irr & ~m_mask, m_low);
    int is = best(m_isr, m_low);
    logic [7:0] nirr = m_mode[0] ? i : (m_irr | (i & ~m_prev));
    logic [7:0] nisr = m_isr;
    int nlow = m_low;
    bit a1 = ak && !m_st, a2 = ak && m_st;
    m_vv = 0;
    if (a1 && win) begin nisr[rq] = 1; nirr[rq] = 0; end
    if (a2 && m_mode[1] && !m_spur) begin
      nisr[m_fz] = 0;
      if (m_mode[2]) nlow = m_fz;
    end
    if (w && a == 3 && d[0] && is >= 0) begin
      nisr[is] = 0;
      if (m_mode[2]) nlow = is;
    end
    if (a2) begin
      m_vv = 1;
      m_vec = {m_base[7:3], m_spur ? 3'd7 : 3'(m_fz)};
    end
    if (a1) begin m_st = 1; m_spur = !win; m_fz = (rq < 0) ? 0 : rq; end
    else if (a2) m_st = 0;
    if (w) begin
      case (a)
        2'd0: m_mode = d[2:0];
        2'd1: m_mask = d;
        2'd2: m_base = d;
        default: ;
      endcase
    end
    m_prev = i; m_irr = nirr; m_isr = nisr; m_low = nlow;
  endtask

  // one clock: drive at negedge, check at the next negedge
  task automatic cyc(logic [7:0] i, bit w, logic [1:0] a, logic [7:0] d, bit ak, bit rs);
    @(negedge clk);
    irq = i; we = w; addr = a; wdata = d; inta = ak; rsel = rs;
    model_step(i, w, a, d, ak);
    @(negedge clk);
    expect_v({tag, " int_o"}, 8'(int_w), 8'(m_int()));
    expect_v({tag, " vec_valid"}, 8'(vv), 8'(m_vv));
    if (m_vv) expect_v({tag, " vec"}, vec, m_vec);
    expect_v({tag, " readback R11"}, rd_data, rs ? m_isr : m_irr);
    we = 0; inta = 0;
  endtask

  task automatic idle(bit rs = 0);  cyc(irq, 0, 0, 0, 0, rs); endtask
  task automatic wr(logic [1:0] a, logic [7:0] d); cyc(irq, 1, a, d, 0, 0); endtask
  task automatic pulse(logic [7:0] i); cyc(i, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0); endtask
  task automatic ack(bit rs = 1); cyc(irq, 0, 0, 0, 1, rs); endtask
  task automatic eoi(); cyc(irq, 1, 3, 8'h01, 0, 1); endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1A2B));
    model_reset();
    #(TCK * 3);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    tag = "R1";
    idle(0); expect_v("R1 irr", rd_data, 8'h00); expect_v("R1 int", 8'(int_w), 0);
    idle(1); expect_v("R1 isr", rd_data, 8'h00); expect_v("R1 vv", 8'(vv), 0);

    // R2 edge capture, R6 vector
    tag = "R2";
    wr(2, 8'h40);
    pulse(8'h08);
    idle(0); expect_v("R2 held", rd_data, 8'h08); expect_v("R5 int", 8'(int_w), 1);
    tag = "R6";
    ack(1); expect_v("R6 isr set", rd_data, 8'h08); expect_v("R12 int low", 8'(int_w), 0);
    idle(0); expect_v("R6 irr cleared", rd_data, 8'h00); expect_v("R12 still low", 8'(int_w), 0);
    ack(1); expect_v("R6 vv", 8'(vv), 1); expect_v("R6 vec", vec, 8'h43);

    // R5 nested ranking, R8 eoi
    tag = "R5";
    pulse(8'h20); expect_v("R5 lower blocked", 8'(int_w), 0);
    pulse(8'h02); expect_v("R5 higher passes", 8'(int_w), 1);
    ack(); ack(); expect_v("R5 vec", vec, 8'h41);
    idle(1); expect_v("R5 isr", rd_data, 8'h0A);
    tag = "R8";
    eoi(); expect_v("R8 top cleared", rd_data, 8'h08); expect_v("R8 int", 8'(int_w), 0);
    eoi(); expect_v("R8 empty", rd_data, 8'h00); expect_v("R8 int", 8'(int_w), 1);
    ack(); ack(); expect_v("R8 vec", vec, 8'h45);
    eoi();

    // R4 mask, R7 spurious
    tag = "R4";
    wr(1, 8'h04);
    pulse(8'h04); idle(0);
    expect_v("R4 captured", rd_data, 8'h04); expect_v("R4 int", 8'(int_w), 0);
    tag = "R7";
    ack(); ack(); expect_v("R7 vec", vec, 8'h47);
    idle(1); expect_v("R7 isr", rd_data, 8'h00);
    tag = "R4";
    wr(1, 8'h00); expect_v("R4 unmask", 8'(int_w), 1);
    ack(); ack(); expect_v("R4 vec", vec, 8'h42);
    eoi();

    // R3 level
    tag = "R3";
    wr(0, 8'h01);
    cyc(8'h10, 0, 0, 0, 0, 0); expect_v("R3 high", rd_data, 8'h10);
    cyc(8'h00, 0, 0, 0, 0, 0); expect_v("R3 low", rd_data, 8'h00);

    // R9 auto end of interrupt
    tag = "R9";
    wr(0, 8'h02);
    pulse(8'h40);
    ack(1); expect_v("R9 in service", rd_data, 8'h40);
    ack(1); expect_v("R9 auto clear", rd_data, 8'h00); expect_v("R9 vec", vec, 8'h46);

    // R10 rotation
    tag = "R10";
    wr(0, 8'h06);
    pulse(8'h04); ack(); ack(); expect_v("R10 vec a", vec, 8'h42);
    pulse(8'h0A); ack(); ack(); expect_v("R10 wrap order", vec, 8'h43);
    ack(); ack(); expect_v("R10 next", vec, 8'h41);
    wr(0, 8'h00);

    // random phase
    tag = "R5 random";
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ri = 8'($urandom & $urandom & $urandom);
      bit w = ($urandom % 10) == 0;
      logic [1:0] a = 2'($urandom);
      logic [7:0] d = 8'($urandom);
      bit ak;
      if (a == 1 && ($urandom % 2)) d = 8'($urandom & $urandom);
      if (m_st) ak = ($urandom % 2) == 0;
      else if (m_int()) ak = ($urandom % 3) == 0;
      else ak = ($urandom % 50) == 0;
      cyc(ri, w, a, d, ak, 1'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule